// File: doc/BRIEF.md
# Rectangle Sprite Rasterizer (16x16)

This block paints up to 32 solid rectangles into a 16x16 framebuffer of 15-bit direct-colour pixels. A processor describes each rectangle in a small sprite memory of two 16-bit words per sprite. It then pulses a start input. The block walks the sprites from the lowest address to the highest. For each enabled sprite it writes every covered pixel, one pixel per clock. A display path reads the framebuffer through a separate combinational read port.

The framebuffer is never cleared by the block. Pixels that no sprite covers keep whatever colour they last had. A scene that needs a clean background therefore places a full-screen sprite at a low address. Because later sprites overwrite earlier ones, the sprite at the highest address appears on top.

Top module: `rect_raster`

## Requirements
- R1: After reset, busy is low, every framebuffer pixel reads 0, and every sprite word is 0, so all sprites start disabled.
- R2: Sprite n occupies word addresses 2n (geometry) and 2n+1 (attributes). In the geometry word, bits 15:12 are the left column, bits 11:8 the right column, bits 7:4 the top row and bits 3:0 the bottom row.
- R3: Corners are inclusive. An enabled sprite fills every pixel whose column lies from left to right and whose row lies from top to bottom, so corners 0,15,0,15 cover all 256 pixels.
- R4: In the attribute word, bits 15:1 are the colour and bit 0 is the enable. A sprite whose enable bit is 0 changes no pixel.
- R5: Sprites are painted in increasing index order, so where rectangles overlap the sprite with the higher index sets the final colour.
- R6: An update does not clear the framebuffer. A pixel that no enabled sprite covers keeps its colour from before the update.
- R7: A sprite whose right column is less than its left column, or whose bottom row is less than its top row, paints nothing.
- R8: The framebuffer read address is row*16 + column, and the pixel appears on fb_rdata in the same cycle. When start is sampled high while the block is idle, busy is high from the next cycle on.
- R9: A start sampled while busy is ignored: the update neither restarts nor lengthens.
- R10: An update keeps busy high for exactly 32 cycles plus one cycle per painted pixel. Each painted pixel counts once per sprite that covers it.
- R11: Sprite-memory writes are accepted during an update. A sprite not yet visited is drawn with its new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Sprite memory write strobe |
| cpu_addr | input | 6 | Sprite memory word address |
| cpu_wdata | input | 16 | Sprite memory write data |
| start | input | 1 | Request one update of the framebuffer |
| busy | output | 1 | High while an update is in progress |
| fb_raddr | input | 8 | Framebuffer read address, row*16 + column |
| fb_rdata | output | 15 | Colour of the addressed pixel |

## Verification
The bench builds the block with its default parameters: 32 sprites and 4-bit coordinates. With these values the full-screen corner case, the single pixel at the bottom-right corner and the top-priority sprite at index 31 are all reachable. A bench-side model repaints all 256 pixels after every update and computes the expected busy length from the painted area. This covers overlap, disabled and inverted rectangles, pixels kept from earlier updates, a start request made during an update, and a write to an unvisited sprite made during an update.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_FETCH = 2'd1,
    WALK_PAINT = 2'd2
  } walk_state_e;
endpackage

// File: rtl/sprite_store.sv
module sprite_store #(
  parameter int SPRITES = 32,
  parameter int WORD_W  = 16,
  parameter int IDX_W   = 5,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] geom_word,
  output logic [WORD_W-1:0] attr_word
);
  localparam int DEPTH = 2 * SPRITES;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // even word holds the rectangle corners, odd word holds colour and enable
  assign geom_word = mem[{rd_idx, 1'b0}];
  assign attr_word = mem[{rd_idx, 1'b1}];
endmodule

// File: rtl/frame_store.sv
module frame_store #(
  parameter int COORD_W = 4,
  parameter int COLOR_W = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2*COORD_W-1:0] wr_addr,
  input  logic [COLOR_W-1:0]   wr_data,
  input  logic [2*COORD_W-1:0] rd_addr,
  output logic [COLOR_W-1:0]   rd_data
);
  localparam int PIXELS = 1 << (2 * COORD_W);

  logic [COLOR_W-1:0] pix [PIXELS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PIXELS; i++) pix[i] <= '0;
    end else if (wr_en) begin
      pix[wr_addr] <= wr_data;
    end
  end

  assign rd_data = pix[rd_addr];
endmodule

// File: rtl/walk_engine.sv
module walk_engine
  import rr_pkg::*;
#(
  parameter int SPRITES = 32,
  parameter int COORD_W = 4,
  parameter int IDX_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [4*COORD_W-1:0]   geom_word,
  input  logic [4*COORD_W-1:0]   attr_word,
  output logic [IDX_W-1:0]       spr_idx,
  output logic                   busy,
  output logic                   paint_we,
  output logic [COORD_W-1:0]     paint_x,
  output logic [COORD_W-1:0]     paint_y,
  output logic [2*COORD_W-1:0]   paint_addr,
  output logic [4*COORD_W-2:0]   paint_color,
  output logic [COORD_W-1:0]     cur_x1,
  output logic [COORD_W-1:0]     cur_x2,
  output logic [COORD_W-1:0]     cur_y1,
  output logic [COORD_W-1:0]     cur_y2,
  output logic                   cur_en
);
  localparam int WORD_W  = 4 * COORD_W;
  localparam int COLOR_W = WORD_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SPRITES - 1);

  // k-th corner field, counted from the top of the geometry word
  function automatic logic [COORD_W-1:0] corner(input logic [WORD_W-1:0] w, input int k);
    return w[WORD_W-1-k*COORD_W -: COORD_W];
  endfunction

  function automatic logic span_void(input logic [COORD_W-1:0] lo, input logic [COORD_W-1:0] hi);
    return hi < lo;
  endfunction

  function automatic logic [2*COORD_W-1:0] pixel_index(input logic [COORD_W-1:0] col,
                                                       input logic [COORD_W-1:0] row);
    return {row, col};
  endfunction

  walk_state_e        state;
  logic [IDX_W-1:0]   idx;
  logic [COORD_W-1:0] cx, cy;
  logic [COORD_W-1:0] g_x1, g_x2, g_y1, g_y2;
  logic [COLOR_W-1:0] g_col;
  logic               g_en;

  logic [COORD_W-1:0] f_x1, f_x2, f_y1, f_y2;
  logic               f_draw;
  logic               last_spr;
  logic               row_end;
  logic               rect_end;

  assign f_x1     = corner(geom_word, 0);
  assign f_x2     = corner(geom_word, 1);
  assign f_y1     = corner(geom_word, 2);
  assign f_y2     = corner(geom_word, 3);
  assign f_draw   = attr_word[0] && !span_void(f_x1, f_x2) && !span_void(f_y1, f_y2);
  assign last_spr = (idx == LAST_IDX);
  assign row_end  = (cx == g_x2);
  assign rect_end = row_end && (cy == g_y2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WALK_IDLE;
      idx   <= '0;
      cx    <= '0;
      cy    <= '0;
      g_x1  <= '0;
      g_x2  <= '0;
      g_y1  <= '0;
      g_y2  <= '0;
      g_col <= '0;
      g_en  <= 1'b0;
    end else begin
      unique case (state)
        WALK_IDLE: begin
          if (start) begin
            state <= WALK_FETCH;
            idx   <= '0;
          end
        end
        WALK_FETCH: begin
          g_x1  <= f_x1;
          g_x2  <= f_x2;
          g_y1  <= f_y1;
          g_y2  <= f_y2;
          g_col <= attr_word[WORD_W-1:1];
          g_en  <= attr_word[0];
          if (f_draw) begin
            state <= WALK_PAINT;
            cx    <= f_x1;
            cy    <= f_y1;
          end else if (last_spr) begin
            state <= WALK_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        WALK_PAINT: begin
          if (rect_end) begin
            if (last_spr) begin
              state <= WALK_IDLE;
            end else begin
              state <= WALK_FETCH;
              idx   <= idx + 1'b1;
            end
          end else if (row_end) begin
            cx <= g_x1;
            cy <= cy + 1'b1;
          end else begin
            cx <= cx + 1'b1;
          end
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  assign spr_idx     = idx;
  assign busy        = (state != WALK_IDLE);
  assign paint_we    = (state == WALK_PAINT);
  assign paint_x     = cx;
  assign paint_y     = cy;
  assign paint_addr  = pixel_index(cx, cy);
  assign paint_color = g_col;
  assign cur_x1      = g_x1;
  assign cur_x2      = g_x2;
  assign cur_y1      = g_y1;
  assign cur_y2      = g_y2;
  assign cur_en      = g_en;
endmodule

// File: rtl/rect_raster.sv
module rect_raster #(
  parameter  int SPRITES = 32,
  parameter  int COORD_W = 4,
  localparam int IDX_W   = $clog2(SPRITES),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int WORD_W  = 4 * COORD_W,
  localparam int COLOR_W = WORD_W - 1,
  localparam int FB_AW   = 2 * COORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic               start,
  output logic               busy,
  input  logic [FB_AW-1:0]   fb_raddr,
  output logic [COLOR_W-1:0] fb_rdata
);
  logic [IDX_W-1:0]   spr_idx;
  logic [WORD_W-1:0]  geom_word;
  logic [WORD_W-1:0]  attr_word;
  logic               paint_we;
  logic [COORD_W-1:0] paint_x, paint_y;
  logic [FB_AW-1:0]   paint_addr;
  logic [COLOR_W-1:0] paint_color;
  logic [COORD_W-1:0] cur_x1, cur_x2, cur_y1, cur_y2;
  logic               cur_en;

  sprite_store #(
    .SPRITES(SPRITES), .WORD_W(WORD_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cpu_we), .wr_addr(cpu_addr), .wr_data(cpu_wdata),
    .rd_idx(spr_idx), .geom_word(geom_word), .attr_word(attr_word)
  );

  walk_engine #(
    .SPRITES(SPRITES), .COORD_W(COORD_W), .IDX_W(IDX_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .geom_word(geom_word), .attr_word(attr_word),
    .spr_idx(spr_idx), .busy(busy),
    .paint_we(paint_we), .paint_x(paint_x), .paint_y(paint_y),
    .paint_addr(paint_addr), .paint_color(paint_color),
    .cur_x1(cur_x1), .cur_x2(cur_x2), .cur_y1(cur_y1), .cur_y2(cur_y2),
    .cur_en(cur_en)
  );

  frame_store #(
    .COORD_W(COORD_W), .COLOR_W(COLOR_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .wr_en(paint_we), .wr_addr(paint_addr), .wr_data(paint_color),
    .rd_addr(fb_raddr), .rd_data(fb_rdata)
  );
endmodule

// File: rtl/rect_raster_chk.sv
module rect_raster_chk #(
  parameter int SPRITES = 32,
  parameter int COORD_W = 4,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               paint_we,
  input logic [COORD_W-1:0] paint_x,
  input logic [COORD_W-1:0] paint_y,
  input logic [COORD_W-1:0] cur_x1,
  input logic [COORD_W-1:0] cur_x2,
  input logic [COORD_W-1:0] cur_y1,
  input logic [COORD_W-1:0] cur_y2,
  input logic               cur_en,
  input logic [IDX_W-1:0]   spr_idx
);
  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_pixel_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    paint_we |-> (paint_x >= cur_x1 && paint_x <= cur_x2 &&
                  paint_y >= cur_y1 && paint_y <= cur_y2));

  assert_paint_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    paint_we |-> cur_en);

  assert_no_void_paint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    paint_we |-> (cur_x1 <= cur_x2 && cur_y1 <= cur_y2));

  assert_index_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> spr_idx >= $past(spr_idx));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && spr_idx != '0) |=> spr_idx != '0);

  assert_end_at_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(spr_idx) == IDX_W'(SPRITES - 1));
endmodule

bind rect_raster rect_raster_chk #(
  .SPRITES(SPRITES), .COORD_W(COORD_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .paint_we(paint_we), .paint_x(paint_x), .paint_y(paint_y),
  .cur_x1(cur_x1), .cur_x2(cur_x2), .cur_y1(cur_y1), .cur_y2(cur_y2),
  .cur_en(cur_en), .spr_idx(spr_idx)
);

// File: tb/test_rect_raster.sv
`timescale 1ns/1ps
module test_rect_raster;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        start = 1'b0;
  logic        busy;
  logic [7:0]  fb_raddr = '0;
  logic [14:0] fb_rdata;

  int checks = 0;
  int fails  = 0;

  logic [15:0] model_ram [64];
  logic [14:0] model_fb  [256];
  int          model_pix;

  always #4 clk = ~clk;

  rect_raster i_rect_raster (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .start(start), .busy(busy),
    .fb_raddr(fb_raddr), .fb_rdata(fb_rdata)
  );

  typedef struct packed {
    int          scn;
    int          addr;
    logic [15:0] data;
  } wr_t;

  // geometry: {left,right,top,bottom}; attributes: {colour,enable} (R2, R4)
  localparam int NTAB = 10;
  localparam int NSCN = 4;
  localparam wr_t TAB [NTAB] = '{
    '{0,  0, 16'h0F0F}, '{0,  1, 16'h2469},   // full-screen background (R3)
    '{1,  1, 16'h2468},                       // background disabled, pixels kept (R6)
    '{1,  4, 16'h2936}, '{1,  5, 16'h02AB},   // sprite 2
    '{1, 10, 16'h6C5A}, '{1, 11, 16'hF801},   // sprite 5 overlaps sprite 2 (R5)
    '{2, 14, 16'h930F}, '{2, 15, 16'h07C1},   // sprite 7: right < left (R7)
    '{2, 62, 16'hFFFF}
  };
  localparam wr_t TAB2 [4] = '{
    '{2, 63, 16'h7FFF},                       // sprite 31: single corner pixel
    '{2, 18, 16'h0F0F},                       // sprite 9 geometry, disabled (R4)
    '{3,  1, 16'h1579},                       // background re-enabled, new colour
    '{3, 20, 16'h0382}                        // sprite 10: bottom < top (R7)
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input int a, input logic [15:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 6'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    model_ram[a] = d;
  endtask

  task automatic model_render();
    model_pix = 0;
    for (int s = 0; s < 32; s++) begin
      int l, r, t, b;
      l = int'(model_ram[2*s][15:12]);
      r = int'(model_ram[2*s][11:8]);
      t = int'(model_ram[2*s][7:4]);
      b = int'(model_ram[2*s][3:0]);
      if (model_ram[2*s+1][0]) begin
        for (int yy = t; yy <= b; yy++)
          for (int xx = l; xx <= r; xx++) begin
            model_fb[yy*16 + xx] = model_ram[2*s+1][15:1];
            model_pix++;
          end
      end
    end
  endtask

  task automatic compare_frame(input string req);
    int bad;
    bad = 0;
    for (int p = 0; p < 256; p++) begin
      fb_raddr = 8'(p);
      #1;
      if (fb_rdata !== model_fb[p] && bad < 4) begin
        bad++;
        check(1'b0, $sformatf("%s pixel %0d", req, p), int'(fb_rdata), int'(model_fb[p]));
      end
    end
    if (bad == 0) check(1'b1, req, 0, 0);
  endtask

  task automatic run_update(input int mid_start, input bit do_wr, input int wa,
                            input logic [15:0] wd, input string req);
    int cnt;
    @(negedge clk);
    check(busy === 1'b0, "R8 idle before start", int'(busy), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R8 busy after start", int'(busy), 1);
    cnt = 0;
    while (busy === 1'b1) begin
      cnt++;
      start     = (cnt == mid_start);
      cpu_we    = do_wr && (cnt == 1);
      cpu_addr  = 6'(wa);
      cpu_wdata = wd;
      @(negedge clk);
    end
    start  = 1'b0;
    cpu_we = 1'b0;
    if (do_wr) model_ram[wa] = wd;
    model_render();
    check(cnt == 32 + model_pix, {"R10 busy length ", req}, cnt, 32 + model_pix);
    compare_frame(req);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model_ram[i] = '0;
    for (int i = 0; i < 256; i++) model_fb[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    compare_frame("R1 framebuffer after reset");

    // table walk: R2 R3 R4 R5 R6 R7 scenarios
    for (int s = 0; s < NSCN; s++) begin
      for (int i = 0; i < NTAB; i++)
        if (TAB[i].scn == s) cpu_write(TAB[i].addr, TAB[i].data);
      for (int i = 0; i < 4; i++)
        if (TAB2[i].scn == s) cpu_write(TAB2[i].addr, TAB2[i].data);
      run_update(0, 1'b0, 0, 16'h0, $sformatf("R3 R4 R5 R6 R7 scenario %0d", s));
    end

    // R8: spot check of address order, row 5 column 6 belongs to sprite 5
    fb_raddr = 8'h56;
    #1;
    check(fb_rdata === 15'h7C00, "R8 row-major address", int'(fb_rdata), 'h7C00);

    // R9: start during update is ignored
    run_update(5, 1'b0, 0, 16'h0, "R9 start while busy");

    // R11: write to unvisited sprite 30 during update
    run_update(0, 1'b1, 61, 16'h2223, "R11 write during update");
    fb_raddr = 8'h00;
    #1;
    check(fb_rdata === 15'h1111, "R11 new sprite drawn", int'(fb_rdata), 'h1111);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule